// File: doc/BRIEF.md
# Dual-Protocol Host Register Bus Front End

This block sits between a host processor bus and the register files of a two-channel serial controller. A static strap input chooses between two bus styles that share one set of pins. In the Intel style there are separate active-low read and write strobes and one active-low chip select per channel. In the Motorola style there is one active-low chip select and a read/write line. The second chip-select pin then becomes a fourth address bit that picks the channel, and the read strobe pin has no effect.

All strobes and selects are brought into the internal clock domain through two-flop synchronisers, and their edges are detected there. Each recognised bus cycle produces exactly one single-cycle read or write pulse toward the addressed channel. The pulse carries the 3-bit register address and, for writes, the data byte. For reads, the block returns the selected channel's register byte on the data bus while the read cycle lasts. The block also maps the two channels' interrupt requests onto the two interrupt pins, and the mapping depends on the bus style. A power-save input cuts the block off from the host bus: while it is high, bus activity causes no register access and the data bus stays released.

Top module: `hostbus_front`

## Requirements
- R1: With `mode_intel`=1, a falling `rd_n` while exactly one chip select is low gives a one-cycle pulse on `reg_rd`. Bit 0 of the pulse means channel A (`cs0_n` low) and bit 1 means channel B (`cs1_n` low). The pulse appears on the third rising clock edge after the strobe change, with `reg_addr` equal to `addr`.
- R2: With `mode_intel`=1, a rising `wr_n` while exactly one chip select is low gives a one-cycle `reg_wr` pulse for that channel on the third rising edge after the rise. The pulse carries `addr` on `reg_addr` and `dq_in` on `reg_wdata`. The falling edge of `wr_n` starts no access.
- R3: With `mode_intel`=0, a falling `cs0_n` while `wr_n`=1 (read) gives a one-cycle `reg_rd` pulse on the third rising edge. The channel is taken from `cs1_n`: 0 selects A and 1 selects B. `rd_n` has no effect in this mode.
- R4: With `mode_intel`=0, a rising `cs0_n` while `wr_n`=0 (write) gives a one-cycle `reg_wr` pulse for the channel chosen by `cs1_n`, on the third rising edge, carrying `addr` and `dq_in`.
- R5: With `mode_intel`=1, when both chip selects are low, strobes cause no access and `dq_oe` stays 0.
- R6: During a recognised read cycle, `dq_oe` is 1 from the third rising edge after the read starts. `dq_out` holds the addressed channel's register byte from the fourth edge. `dq_oe` returns to 0 on the third edge after the read condition ends.
- R7: With `mode_intel`=1, for each channel i: `int_oe[i]` equals `irq_en[i]` (the channel's control bit 3), `int_out[i]` follows `irq_req[i]`, and `op2_n[i]` is the inverse of `irq_en[i]`.
- R8: With `mode_intel`=0, pin 0 acts as an open-drain active-low device interrupt. `int_out[0]`=0, and `int_oe[0]`=1 exactly when either channel requests. Pin 1 is driven to logic 0 (`int_oe[1]`=1, `int_out[1]`=0).
- R9: While `pwr_save`=1, no `reg_rd` or `reg_wr` pulse follows any bus activity, and `dq_oe` is 0 at once. Register contents seen afterwards are unchanged by that activity.
- R10: After reset, `reg_rd`, `reg_wr`, `dq_oe` and `dq_out` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_intel | input | 1 | Static strap: 1 Intel style, 0 Motorola style |
| pwr_save | input | 1 | High isolates the block from the host bus |
| rd_n | input | 1 | Read strobe (Intel); unused (Motorola) |
| wr_n | input | 1 | Write strobe (Intel); read/write line, 1 = read (Motorola) |
| cs0_n | input | 1 | Channel A select (Intel); device select (Motorola) |
| cs1_n | input | 1 | Channel B select (Intel); channel address bit (Motorola) |
| addr | input | 3 | Register address |
| dq_in | input | 8 | Data bus input |
| dq_out | output | 8 | Data bus output value |
| dq_oe | output | 1 | Data bus output enable |
| reg_rd | output | 2 | One-hot per-channel register read pulse |
| reg_wr | output | 2 | One-hot per-channel register write pulse |
| reg_addr | output | 3 | Register address for the pulse |
| reg_wdata | output | 8 | Write data for the pulse |
| ch0_rdata | input | 8 | Channel A register read data for `reg_addr` |
| ch1_rdata | input | 8 | Channel B register read data for `reg_addr` |
| irq_req | input | 2 | Per-channel interrupt request |
| irq_en | input | 2 | Per-channel interrupt output enable (control bit 3) |
| int_out | output | 2 | Interrupt pin values |
| int_oe | output | 2 | Interrupt pin output enables |
| op2_n | output | 2 | Per-channel general output, low when enabled |

## Verification
Every bus-side result has a fixed latency counted from the clock edge at which the host pin is first sampled. Two synchroniser stages and one pulse register put `reg_rd`/`reg_wr` and `dq_oe` at the third rising edge and the read byte at the fourth. The bench drives pins on falling clock edges, waits exactly that many rising edges, and samples at the next falling edge. It then samples once more a cycle later to confirm that each pulse lasts a single cycle. The interrupt mapping is combinational, so it is sampled one falling edge after its inputs change. Cases where no access may occur (both selects low, the read strobe in Motorola style, power save) are judged by pulse counters kept over the whole window, and by reading the register back afterwards.

// File: rtl/hbf_pkg.sv
package hbf_pkg;
    localparam int HBF_ADDR_W = 3;
    localparam int HBF_DATA_W = 8;
    localparam int HBF_N_CH   = 2;
    // bit positions of the synchronised control pins
    localparam int HBF_BUS_W  = 4;
    localparam int IDX_RD     = 0;
    localparam int IDX_WR     = 1;
    localparam int IDX_CS0    = 2;
    localparam int IDX_CS1    = 3;
endpackage

// File: rtl/hbf_sync.sv
module hbf_sync #(
    parameter int             W       = 4,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    generate
        for (genvar i = 0; i < W; i++) begin : g_bit
            logic [STAGES-1:0] stg_d, stg_q;
            always_comb begin
                stg_d = {stg_q[STAGES-2:0], async_i[i]};
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q <= {STAGES{RST_VAL[i]}};
                else        stg_q <= stg_d;
            end
            assign sync_o[i] = stg_q[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/hbf_decode.sv
module hbf_decode
    import hbf_pkg::*;
#(
    parameter int ADDR_W = HBF_ADDR_W,
    parameter int DATA_W = HBF_DATA_W,
    parameter int N_CH   = HBF_N_CH,
    parameter int BUS_W  = HBF_BUS_W
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         mode_intel,
    input  logic [BUS_W-1:0]             bus_s,
    input  logic [ADDR_W-1:0]            addr_i,
    input  logic [DATA_W-1:0]            data_i,
    input  logic [N_CH-1:0][DATA_W-1:0]  ch_rdata,
    output logic [N_CH-1:0]              rd_p,
    output logic [N_CH-1:0]              wr_p,
    output logic [ADDR_W-1:0]            addr_o,
    output logic [DATA_W-1:0]            wdata_o,
    output logic [DATA_W-1:0]            rdata_o,
    output logic                         oe_o
);
    localparam int CH_W = (N_CH > 1) ? $clog2(N_CH) : 1;

    typedef struct packed {
        logic [BUS_W-1:0]  prev;
        logic [N_CH-1:0]   rd_p;
        logic [N_CH-1:0]   wr_p;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [CH_W-1:0]   ch;
        logic              oe;
        logic [DATA_W-1:0] rdata;
    } dec_st_t;

    dec_st_t st_d, st_q;

    logic            rd_go, wr_go, rd_act;
    logic [CH_W-1:0] ch_sel;
    logic [N_CH-1:0] sel_vec;
    logic            cs0_l, cs1_l, one_sel;

    // cycle recognition for both bus styles
    always_comb begin
        cs0_l   = ~bus_s[IDX_CS0];
        cs1_l   = ~bus_s[IDX_CS1];
        one_sel = cs0_l ^ cs1_l;
        ch_sel  = '0;
        rd_go   = 1'b0;
        wr_go   = 1'b0;
        rd_act  = 1'b0;
        if (mode_intel) begin
            ch_sel = CH_W'(cs1_l);
            rd_go  = one_sel &  st_q.prev[IDX_RD] & ~bus_s[IDX_RD];
            wr_go  = one_sel & ~st_q.prev[IDX_WR] &  bus_s[IDX_WR];
            rd_act = one_sel & ~bus_s[IDX_RD];
        end else begin
            ch_sel = CH_W'(bus_s[IDX_CS1]);
            rd_go  =  st_q.prev[IDX_CS0] & ~bus_s[IDX_CS0] &  bus_s[IDX_WR];
            wr_go  = ~st_q.prev[IDX_CS0] &  bus_s[IDX_CS0] & ~bus_s[IDX_WR];
            rd_act =  cs0_l & bus_s[IDX_WR];
        end
        sel_vec         = '0;
        sel_vec[ch_sel] = 1'b1;
    end

    always_comb begin
        st_d      = st_q;
        st_d.prev = bus_s;
        st_d.rd_p = '0;
        st_d.wr_p = '0;
        st_d.oe   = rd_act;
        if (rd_go || wr_go) begin
            st_d.addr = addr_i;
            st_d.ch   = ch_sel;
        end
        if (rd_go) st_d.rd_p = sel_vec;
        if (wr_go) begin
            st_d.wr_p  = sel_vec;
            st_d.wdata = data_i;
        end
        if (|st_q.rd_p) st_d.rdata = ch_rdata[st_q.ch];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.prev <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_p    = st_q.rd_p;
    assign wr_p    = st_q.wr_p;
    assign addr_o  = st_q.addr;
    assign wdata_o = st_q.wdata;
    assign rdata_o = st_q.rdata;
    assign oe_o    = st_q.oe;
endmodule

// File: rtl/hbf_irq_map.sv
module hbf_irq_map
    import hbf_pkg::*;
#(
    parameter int N_CH = HBF_N_CH
) (
    input  logic            mode_intel,
    input  logic [N_CH-1:0] irq_req,
    input  logic [N_CH-1:0] irq_en,
    output logic [N_CH-1:0] int_out,
    output logic [N_CH-1:0] int_oe,
    output logic [N_CH-1:0] op2_n
);
    logic any_req;
    assign any_req = |irq_req;

    generate
        for (genvar i = 0; i < N_CH; i++) begin : g_ch
            logic out_d, oe_d;
            always_comb begin
                if (mode_intel) begin
                    out_d = irq_req[i];
                    oe_d  = irq_en[i];
                end else if (i == 0) begin
                    out_d = 1'b0;
                    oe_d  = any_req;
                end else begin
                    out_d = 1'b0;
                    oe_d  = 1'b1;
                end
            end
            assign int_out[i] = out_d;
            assign int_oe[i]  = oe_d;
            assign op2_n[i]   = ~irq_en[i];
        end
    endgenerate
endmodule

// File: rtl/hostbus_front.sv
module hostbus_front
    import hbf_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  mode_intel,
    input  logic                  pwr_save,
    input  logic                  rd_n,
    input  logic                  wr_n,
    input  logic                  cs0_n,
    input  logic                  cs1_n,
    input  logic [HBF_ADDR_W-1:0] addr,
    input  logic [HBF_DATA_W-1:0] dq_in,
    output logic [HBF_DATA_W-1:0] dq_out,
    output logic                  dq_oe,
    output logic [HBF_N_CH-1:0]   reg_rd,
    output logic [HBF_N_CH-1:0]   reg_wr,
    output logic [HBF_ADDR_W-1:0] reg_addr,
    output logic [HBF_DATA_W-1:0] reg_wdata,
    input  logic [HBF_DATA_W-1:0] ch0_rdata,
    input  logic [HBF_DATA_W-1:0] ch1_rdata,
    input  logic [HBF_N_CH-1:0]   irq_req,
    input  logic [HBF_N_CH-1:0]   irq_en,
    output logic [HBF_N_CH-1:0]   int_out,
    output logic [HBF_N_CH-1:0]   int_oe,
    output logic [HBF_N_CH-1:0]   op2_n
);
    logic [HBF_BUS_W-1:0] bus_raw, bus_gated, bus_s;
    logic                 oe_q;
    logic [HBF_N_CH-1:0][HBF_DATA_W-1:0] rdata_vec;

    // isolation: while in power save every control pin looks idle (high)
    always_comb begin
        bus_raw          = '1;
        bus_raw[IDX_RD]  = rd_n;
        bus_raw[IDX_WR]  = wr_n;
        bus_raw[IDX_CS0] = cs0_n;
        bus_raw[IDX_CS1] = cs1_n;
        bus_gated        = pwr_save ? '1 : bus_raw;
    end

    assign rdata_vec[0] = ch0_rdata;
    assign rdata_vec[1] = ch1_rdata;

    hbf_sync #(.W(HBF_BUS_W), .STAGES(2), .RST_VAL('1)) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (bus_gated),
        .sync_o  (bus_s)
    );

    hbf_decode dec_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_intel (mode_intel),
        .bus_s      (bus_s),
        .addr_i     (addr),
        .data_i     (dq_in),
        .ch_rdata   (rdata_vec),
        .rd_p       (reg_rd),
        .wr_p       (reg_wr),
        .addr_o     (reg_addr),
        .wdata_o    (reg_wdata),
        .rdata_o    (dq_out),
        .oe_o       (oe_q)
    );

    assign dq_oe = oe_q & ~pwr_save;

    hbf_irq_map irq_i (
        .mode_intel (mode_intel),
        .irq_req    (irq_req),
        .irq_en     (irq_en),
        .int_out    (int_out),
        .int_oe     (int_oe),
        .op2_n      (op2_n)
    );
endmodule

// File: rtl/hbf_chk.sv
module hbf_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       mode_intel,
    input logic       pwr_save,
    input logic       dq_oe,
    input logic [1:0] reg_rd,
    input logic [1:0] reg_wr,
    input logic [1:0] irq_req,
    input logic [1:0] int_out,
    input logic [1:0] int_oe,
    input logic [1:0] op2_n
);
    // R1
    rd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|reg_rd) |=> (reg_rd == 2'b00));
    // R2
    wr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|reg_wr) |=> (reg_wr == 2'b00));
    // R3
    pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({reg_rd, reg_wr}));
    // R6
    oe_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> (reg_wr == 2'b00));
    // R9
    psave_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_save |-> !dq_oe);
    // R9
    psave_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_save && $past(pwr_save, 3) && $past(pwr_save, 4))
        |-> (reg_rd == 2'b00 && reg_wr == 2'b00));
    // R7
    intel_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_intel |-> (int_oe == ~op2_n));
    // R8
    moto_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_intel |-> (int_out == 2'b00 && int_oe[1]));
    // R8
    moto_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_intel && (|irq_req)) |-> int_oe[0]);
endmodule

bind hostbus_front hbf_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_intel (mode_intel),
    .pwr_save   (pwr_save),
    .dq_oe      (dq_oe),
    .reg_rd     (reg_rd),
    .reg_wr     (reg_wr),
    .irq_req    (irq_req),
    .int_out    (int_out),
    .int_oe     (int_oe),
    .op2_n      (op2_n)
);

// File: tb/hostbus_front_tb_top.sv
module hostbus_front_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_intel = 1'b1;
    logic       pwr_save = 1'b0;
    logic       rd_n = 1'b1, wr_n = 1'b1, cs0_n = 1'b1, cs1_n = 1'b1;
    logic [2:0] addr = '0;
    logic [7:0] dq_in = '0;
    logic [7:0] dq_out;
    logic       dq_oe;
    logic [1:0] reg_rd, reg_wr;
    logic [2:0] reg_addr;
    logic [7:0] reg_wdata;
    logic [7:0] ch0_rdata, ch1_rdata;
    logic [1:0] irq_req = '0;
    logic [1:0] irq_en;
    logic [1:0] int_out, int_oe, op2_n;

    int total = 0;
    int bad   = 0;
    int rd_cnt = 0;
    int wr_cnt = 0;

    always #5 clk = ~clk;

    hostbus_front dut_i (.*);

    // register stubs for the two channels
    logic [7:0] regs_a [8];
    logic [7:0] regs_b [8];
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < 8; i++) begin
                regs_a[i] <= '0;
                regs_b[i] <= '0;
            end
        end else begin
            if (reg_wr[0]) regs_a[reg_addr] <= reg_wdata;
            if (reg_wr[1]) regs_b[reg_addr] <= reg_wdata;
        end
    end
    assign ch0_rdata = regs_a[reg_addr];
    assign ch1_rdata = regs_b[reg_addr];
    assign irq_en    = {regs_b[4][3], regs_a[4][3]};

    always_ff @(posedge clk) begin
        if (rst_n) begin
            if (|reg_rd) rd_cnt <= rd_cnt + 1;
            if (|reg_wr) wr_cnt <= wr_cnt + 1;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sel_intel(input int ch);
        cs0_n = (ch != 0);
        cs1_n = (ch == 0);
    endtask

    task automatic intel_write(input int ch, input logic [2:0] a, input logic [7:0] d);
        addr = a; dq_in = d; sel_intel(ch);
        tick(1); wr_n = 1'b0;
        tick(2); wr_n = 1'b1;
        tick(3);
        chk("R2 intel write pulse", 32'(reg_wr), 32'(1 << ch));
        chk("R2 intel write addr", 32'(reg_addr), 32'(a));
        chk("R2 intel write data", 32'(reg_wdata), 32'(d));
        tick(1);
        chk("R2 intel write single cycle", 32'(reg_wr), 32'h0);
        cs0_n = 1'b1; cs1_n = 1'b1;
        tick(2);
    endtask

    task automatic intel_read(input int ch, input logic [2:0] a, input logic [7:0] exp);
        addr = a; sel_intel(ch);
        tick(1); rd_n = 1'b0;
        tick(3);
        chk("R1 intel read pulse", 32'(reg_rd), 32'(1 << ch));
        chk("R1 intel read addr", 32'(reg_addr), 32'(a));
        chk("R6 oe on third edge", 32'(dq_oe), 32'h1);
        tick(1);
        chk("R1 intel read single cycle", 32'(reg_rd), 32'h0);
        chk("R6 read data", 32'(dq_out), 32'(exp));
        rd_n = 1'b1;
        tick(3);
        chk("R6 oe released", 32'(dq_oe), 32'h0);
        cs0_n = 1'b1; cs1_n = 1'b1;
        tick(2);
    endtask

    task automatic moto_write(input int ch, input logic [2:0] a, input logic [7:0] d);
        wr_n = 1'b0; cs1_n = (ch != 0); addr = a; dq_in = d;
        tick(1); cs0_n = 1'b0;
        tick(2); cs0_n = 1'b1;
        tick(3);
        chk("R4 moto write pulse", 32'(reg_wr), 32'(1 << ch));
        chk("R4 moto write addr", 32'(reg_addr), 32'(a));
        chk("R4 moto write data", 32'(reg_wdata), 32'(d));
        tick(1);
        chk("R4 moto write single cycle", 32'(reg_wr), 32'h0);
        wr_n = 1'b1; cs1_n = 1'b1;
        tick(2);
    endtask

    task automatic moto_read(input int ch, input logic [2:0] a, input logic [7:0] exp);
        wr_n = 1'b1; cs1_n = (ch != 0); addr = a;
        tick(1); cs0_n = 1'b0;
        tick(3);
        chk("R3 moto read pulse", 32'(reg_rd), 32'(1 << ch));
        chk("R3 moto read addr", 32'(reg_addr), 32'(a));
        tick(1);
        chk("R6 moto read data", 32'(dq_out), 32'(exp));
        chk("R6 moto oe", 32'(dq_oe), 32'h1);
        cs0_n = 1'b1;
        tick(3);
        chk("R6 moto oe released", 32'(dq_oe), 32'h0);
        cs1_n = 1'b1;
        tick(2);
    endtask

    // {mode_intel, channel, is_write, addr[2:0], data/expected[7:0]}
    localparam logic [13:0] VEC [9] = '{
        {1'b1, 1'b0, 1'b1, 3'd3, 8'h5A},
        {1'b1, 1'b1, 1'b1, 3'd3, 8'hC3},
        {1'b1, 1'b0, 1'b0, 3'd3, 8'h5A},
        {1'b1, 1'b1, 1'b0, 3'd3, 8'hC3},
        {1'b0, 1'b1, 1'b1, 3'd7, 8'h96},
        {1'b0, 1'b0, 1'b1, 3'd0, 8'h11},
        {1'b0, 1'b1, 1'b0, 3'd7, 8'h96},
        {1'b0, 1'b0, 1'b0, 3'd0, 8'h11},
        {1'b1, 1'b1, 1'b0, 3'd7, 8'h96}
    };

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int rc, wc;
        tick(3);
        rst_n = 1'b1;
        tick(2);
        // R10 reset state
        chk("R10 reset reg_rd", 32'(reg_rd), 32'h0);
        chk("R10 reset reg_wr", 32'(reg_wr), 32'h0);
        chk("R10 reset dq_oe", 32'(dq_oe), 32'h0);
        chk("R10 reset dq_out", 32'(dq_out), 32'h0);
        chk("R7 reset int_oe", 32'(int_oe), 32'h0);
        chk("R7 reset op2_n", 32'(op2_n), 32'h3);

        foreach (VEC[k]) begin
            mode_intel = VEC[k][13];
            tick(1);
            if (VEC[k][13]) begin
                if (VEC[k][11]) intel_write(int'(VEC[k][12]), VEC[k][10:8], VEC[k][7:0]);
                else            intel_read (int'(VEC[k][12]), VEC[k][10:8], VEC[k][7:0]);
            end else begin
                if (VEC[k][11]) moto_write(int'(VEC[k][12]), VEC[k][10:8], VEC[k][7:0]);
                else            moto_read (int'(VEC[k][12]), VEC[k][10:8], VEC[k][7:0]);
            end
        end

        // R5 both selects low in Intel style
        mode_intel = 1'b1; tick(1);
        rc = rd_cnt; wc = wr_cnt;
        cs0_n = 1'b0; cs1_n = 1'b0; addr = 3'd3; dq_in = 8'hEE;
        tick(1); rd_n = 1'b0;
        tick(4);
        chk("R5 no oe with both selects", 32'(dq_oe), 32'h0);
        rd_n = 1'b1; tick(1);
        wr_n = 1'b0; tick(2); wr_n = 1'b1; tick(4);
        chk("R5 no read pulse", 32'(rd_cnt), 32'(rc));
        chk("R5 no write pulse", 32'(wr_cnt), 32'(wc));
        cs0_n = 1'b1; cs1_n = 1'b1; tick(2);
        intel_read(0, 3'd3, 8'h5A);

        // R3 read strobe ignored in Motorola style
        mode_intel = 1'b0; tick(1);
        rc = rd_cnt;
        rd_n = 1'b0; tick(3); rd_n = 1'b1; tick(3);
        wr_n = 1'b0; cs1_n = 1'b0; addr = 3'd5; dq_in = 8'h00;
        tick(1); cs0_n = 1'b0; rd_n = 1'b0;
        tick(4);
        chk("R3 rd_n ignored no oe", 32'(dq_oe), 32'h0);
        chk("R3 rd_n ignored no read", 32'(rd_cnt), 32'(rc));
        cs0_n = 1'b1; rd_n = 1'b1; tick(4);
        wr_n = 1'b1; cs1_n = 1'b1; tick(2);

        // R9 power save isolation
        mode_intel = 1'b1; tick(1);
        pwr_save = 1'b1; tick(2);
        rc = rd_cnt; wc = wr_cnt;
        addr = 3'd3; dq_in = 8'hFF; sel_intel(0);
        tick(1); wr_n = 1'b0; tick(2); wr_n = 1'b1; tick(2);
        rd_n = 1'b0; tick(4);
        chk("R9 no oe in power save", 32'(dq_oe), 32'h0);
        rd_n = 1'b1; tick(3);
        chk("R9 no write in power save", 32'(wr_cnt), 32'(wc));
        chk("R9 no read in power save", 32'(rd_cnt), 32'(rc));
        cs0_n = 1'b1; cs1_n = 1'b1; tick(3);
        pwr_save = 1'b0; tick(3);
        intel_read(0, 3'd3, 8'h5A);

        // R7 Intel interrupt mapping
        intel_write(0, 3'd4, 8'h08);
        irq_req = 2'b01; tick(1);
        chk("R7 int_oe", 32'(int_oe), 32'h1);
        chk("R7 int_out", 32'(int_out[0]), 32'h1);
        chk("R7 op2_n", 32'(op2_n), 32'h2);
        irq_req = 2'b00; tick(1);
        chk("R7 int_out follows request", 32'(int_out[0]), 32'h0);

        // R8 Motorola interrupt mapping
        mode_intel = 1'b0; irq_req = 2'b10; tick(1);
        chk("R8 open drain pulls low", 32'(int_oe[0]), 32'h1);
        chk("R8 int pin values", 32'(int_out), 32'h0);
        chk("R8 second pin driven", 32'(int_oe[1]), 32'h1);
        irq_req = 2'b00; tick(1);
        chk("R8 open drain released", 32'(int_oe[0]), 32'h0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule